// File: doc/BRIEF.md
# I2C Dual Wiper Position Controller

This block is the digital core of a two-channel, 256-position resistor-string potentiometer. It listens as a write-only slave on a two-wire I2C bus and keeps two independent 8-bit position registers, channel A and channel B. A system clock runs at least eight times the SCL rate. It oversamples SCL and SDA through two-flop synchronisers and finds bus edges, START, repeated START and STOP. It also drives an open-drain pull-down enable for acknowledges.

A valid write frame has four parts: the matching 7-bit address with the R/W bit clear, then a command byte, then a data byte, then STOP. The low two bits of the command byte choose which position registers take the data byte. A chosen register takes the new value as soon as the last data bit has been clocked in, with no separate load strobe. Each channel gives its position as an 8-bit code and as a one-hot 256-line tap select. Both registers come out of reset at mid-scale.

No part of the block uses a valid/ready stream. The bus carries the only data, and the bus cannot be stalled, because this block never stretches the clock. Every accepted byte is therefore consumed in the cycle it completes. All pins are plain level or strobe signals.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset both position outputs read 80h, each tap select has only bit 128 set, and the SDA pull-down enable is low.
- R2: A frame whose address byte carries the configured 7-bit address (default 2Ch) in bits 7..1 with bit 0 (R/W) equal to 0 is acknowledged. The command and data bytes that follow are acknowledged too. Each acknowledge is the pull-down enable held high from the falling SCL edge after the eighth bit to the falling edge of the ninth clock.
- R3: An address byte with a different address, or with R/W equal to 1, gets no acknowledge. Nothing is acknowledged or written until the next START or STOP.
- R4: Command bit 0 set and bit 1 clear writes the data byte to channel A only.
- R5: Command bit 1 set and bit 0 clear writes the data byte to channel B only.
- R6: Command bits 1 and 0 both set write the same data byte to both channels.
- R7: Command bits 1 and 0 both clear: the data byte is acknowledged, and neither position changes.
- R8: Each tap select is one-hot, with its set bit at the index equal to that channel's position, in the same cycle as the position.
- R9: A position changes only once all eight data bits have arrived. A STOP in the middle of the data byte leaves both positions unchanged.
- R10: A repeated START in the middle of a byte discards that byte and restarts the address phase. A complete frame after it is then carried out normally.
- R11: Bytes after the data byte within the same frame get no acknowledge and change no position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain acknowledge) |
| wiper_a_o | output | 8 | Channel A position code |
| wiper_b_o | output | 8 | Channel B position code |
| tap_a_o | output | 256 | Channel A one-hot tap select |
| tap_b_o | output | 256 | Channel B one-hot tap select |

## Verification
The hardest states to reach from the pins are the bus conditions that land inside a byte: a STOP after five data bits, or a repeated START after three command bits. A byte-level driver never produces these. The bench therefore drives the bus one bit at a time, so a frame can be cut at any bit and closed with STOP or reopened with START. A behavioural model then predicts, clock by clock, when each acknowledge rises and falls and when each position moves. It does this from the exact SCL edges the bench produced.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_WIPERS = 2;
  localparam int SEL_A      = 0;
  localparam int SEL_B      = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_DONE,
    ST_IGNORE
  } frame_st_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[s] <= RST_VAL;
          else         ff_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) ff_q[s] <= RST_VAL;
          else         ff_q[s] <= ff_q[s-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_s, sda_s;
  logic scl_prev_q, sda_prev_q;

  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s)
  );
  sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  // SDA moves while SCL is steady high: a bus condition, never a data bit
  logic scl_held_high;
  assign scl_held_high = scl_s & scl_prev_q;

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_o    = scl_held_high & sda_prev_q & ~sda_s;
  assign stop_o     = scl_held_high & ~sda_prev_q & sda_s;
endmodule

// File: rtl/wiper_frame_fsm.sv
module wiper_frame_fsm
  import wiper_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         POS_W    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sda_s_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  output logic                  sda_pull_o,
  output logic [NUM_WIPERS-1:0] wr_sel_o,
  output logic [POS_W-1:0]      wr_data_o,
  output frame_st_t             state_o
);
  localparam int               CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  frame_st_t              st_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [BYTE_W-1:0]      shreg_q;
  logic [NUM_WIPERS-1:0]  cmd_q;
  logic                   ack_ph_q;
  logic                   pull_q;
  logic [NUM_WIPERS-1:0]  wr_sel_q;
  logic [POS_W-1:0]       wr_data_q;
  logic                   addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == DEV_ADDR) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      cmd_q     <= '0;
      ack_ph_q  <= 1'b0;
      pull_q    <= 1'b0;
      wr_sel_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_sel_q <= '0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        pull_q   <= 1'b0;
      end else if (scl_rise_i && !ack_ph_q && cnt_q != LAST_BIT) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda_s_i};
        cnt_q   <= cnt_q + CNT_W'(1);
      end else if (scl_fall_i && ack_ph_q) begin
        ack_ph_q <= 1'b0;
        pull_q   <= 1'b0;
        cnt_q    <= '0;
      end else if (scl_fall_i && cnt_q == LAST_BIT) begin
        ack_ph_q <= 1'b1;
        unique case (st_q)
          ST_ADDR: begin
            if (addr_hit) begin
              pull_q <= 1'b1;
              st_q   <= ST_CMD;
            end else begin
              st_q   <= ST_IGNORE;
            end
          end
          ST_CMD: begin
            cmd_q  <= shreg_q[NUM_WIPERS-1:0];
            pull_q <= 1'b1;
            st_q   <= ST_DATA;
          end
          ST_DATA: begin
            wr_sel_q  <= cmd_q;
            wr_data_q <= shreg_q[POS_W-1:0];
            pull_q    <= 1'b1;
            st_q      <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_sel_o   = wr_sel_q;
  assign wr_data_o  = wr_data_q;
  assign state_o    = st_q;
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int               POS_W   = 8,
  parameter logic [POS_W-1:0] RST_POS = POS_W'(1 << (POS_W - 1)),
  localparam int              NTAPS   = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [POS_W-1:0] wr_data_i,
  output logic [POS_W-1:0] pos_o,
  output logic [NTAPS-1:0] tap_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      pos_q <= RST_POS;
    else if (wr_en_i) pos_q <= wr_data_i;

  generate
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      assign tap_o[t] = (pos_q == POS_W'(t));
    end
  endgenerate

  assign pos_o = pos_q;
endmodule

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c
  import wiper_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter int         POS_W       = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        NTAPS       = 1 << POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [POS_W-1:0] wiper_a_o,
  output logic [POS_W-1:0] wiper_b_o,
  output logic [NTAPS-1:0] tap_a_o,
  output logic [NTAPS-1:0] tap_b_o
);
  logic                  sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [NUM_WIPERS-1:0] wr_sel;
  logic [POS_W-1:0]      wr_data;
  frame_st_t             frame_st;
  logic [POS_W-1:0]      pos_all [NUM_WIPERS];
  logic [NTAPS-1:0]      tap_all [NUM_WIPERS];

  bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  wiper_frame_fsm #(.DEV_ADDR(DEV_ADDR), .POS_W(POS_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_pull_o (sda_pull_o),
    .wr_sel_o   (wr_sel),
    .wr_data_o  (wr_data),
    .state_o    (frame_st)
  );

  generate
    for (genvar c = 0; c < NUM_WIPERS; c++) begin : g_chan
      wiper_chan #(.POS_W(POS_W)) u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_sel[c]),
        .wr_data_i (wr_data),
        .pos_o     (pos_all[c]),
        .tap_o     (tap_all[c])
      );
    end
  endgenerate

  assign wiper_a_o = pos_all[SEL_A];
  assign wiper_b_o = pos_all[SEL_B];
  assign tap_a_o   = tap_all[SEL_A];
  assign tap_b_o   = tap_all[SEL_B];
endmodule

// File: rtl/dual_wiper_i2c_chk.sv
module dual_wiper_i2c_chk
  import wiper_pkg::*;
#(
  parameter int  POS_W = 8,
  localparam int NTAPS = 1 << POS_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_pull_o,
  input logic                  scl_fall,
  input frame_st_t             frame_st,
  input logic [NUM_WIPERS-1:0] wr_sel,
  input logic [POS_W-1:0]      wiper_a_o,
  input logic [POS_W-1:0]      wiper_b_o,
  input logic [NTAPS-1:0]      tap_a_o,
  input logic [NTAPS-1:0]      tap_b_o
);
  assert_ack_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> $past(scl_fall));

  assert_no_ack_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_st == ST_IGNORE) |-> !sda_pull_o);

  assert_a_moves_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wiper_a_o != $past(wiper_a_o)) |-> $past(wr_sel[SEL_A]));

  assert_b_moves_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wiper_b_o != $past(wiper_b_o)) |-> $past(wr_sel[SEL_B]));

  assert_tap_a_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(tap_a_o) == 1) && tap_a_o[wiper_a_o]);

  assert_tap_b_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(tap_b_o) == 1) && tap_b_o[wiper_b_o]);

  assert_write_after_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_sel) |-> ($past(frame_st) == ST_DATA));

  assert_no_write_in_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((frame_st == ST_DONE) && ($past(frame_st) == ST_DONE)) |-> !(|wr_sel));
endmodule

bind dual_wiper_i2c dual_wiper_i2c_chk #(.POS_W(POS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_pull_o (sda_pull_o),
  .scl_fall   (scl_fall),
  .frame_st   (frame_st),
  .wr_sel     (wr_sel),
  .wiper_a_o  (wiper_a_o),
  .wiper_b_o  (wiper_b_o),
  .tap_a_o    (tap_a_o),
  .tap_b_o    (tap_b_o)
);

// File: tb/dual_wiper_i2c_tb.sv
module dual_wiper_i2c_tb;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int NT = 256;
  localparam int K_SET = 0, K_CLR = 1, K_WA = 2, K_WB = 3;
  localparam int M_IDLE = 0, M_ADDR = 1, M_CMD = 2, M_DATA = 3, M_DONE = 4, M_IGN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic pull;
  logic [7:0] wa, wb;
  logic [NT-1:0] ta, tb;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~pull;

  dual_wiper_i2c #(.DEV_ADDR(DEV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .wiper_a_o(wa), .wiper_b_o(wb), .tap_a_o(ta), .tap_b_o(tb)
  );

  int n_cmp = 0, n_bad = 0;
  bit run_cmp = 0, finished = 0;
  // reference model state
  logic [7:0] exp_a = 8'h80, exp_b = 8'h80;
  logic exp_pull = 1'b0;
  int m_state = M_IDLE;
  logic [7:0] m_cmd = 8'h00;
  bit m_ack = 0;
  int ev_cnt[$], ev_kind[$], ev_val[$];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input int cnt, input int kind, input int val);
    ev_cnt.push_back(cnt); ev_kind.push_back(kind); ev_val.push_back(val);
  endtask

  // clock-by-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      for (int i = 0; i < ev_cnt.size(); i++) ev_cnt[i]--;
      for (int i = ev_cnt.size() - 1; i >= 0; i--) begin
        if (ev_cnt[i] == 0) begin
          case (ev_kind[i])
            K_SET: exp_pull = 1'b1;
            K_CLR: exp_pull = 1'b0;
            K_WA:  exp_a = 8'(ev_val[i]);
            default: exp_b = 8'(ev_val[i]);
          endcase
          ev_cnt.delete(i); ev_kind.delete(i); ev_val.delete(i);
        end
      end
      check("R4 pos_a", int'(wa), int'(exp_a));
      check("R5 pos_b", int'(wb), int'(exp_b));
      n_cmp++;
      if (ta !== ({{(NT-1){1'b0}}, 1'b1} << exp_a) || tb !== ({{(NT-1){1'b0}}, 1'b1} << exp_b)) begin
        n_bad++;
        $display("FAIL R8 tap: actual a%0d/b%0d expected one-hot %0d/%0d", $countones(ta), $countones(tb), exp_a, exp_b);
      end
      check("R2 ack pull", int'(pull), int'(exp_pull));
    end
  end

  // model decision at the falling edge ending bit 8 of a byte
  task automatic model_byte(input logic [7:0] v);
    m_ack = 0;
    case (m_state)
      M_ADDR: begin
        if (v[7:1] == DEV && !v[0]) begin m_ack = 1; m_state = M_CMD; end
        else m_state = M_IGN;
      end
      M_CMD: begin m_cmd = v; m_ack = 1; m_state = M_DATA; end
      M_DATA: begin
        m_ack = 1; m_state = M_DONE;
        if (m_cmd[0]) push(4, K_WA, int'(v));
        if (m_cmd[1]) push(4, K_WB, int'(v));
      end
      default: ;
    endcase
    if (m_ack) push(3, K_SET, 0);
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b, output logic seen);
    cw(2); sda_m = b; cw(4); scl = 1'b1; cw(4); seen = sda_line; cw(4); scl = 1'b0;
  endtask

  task automatic bus_start();
    cw(2); sda_m = 1'b1; cw(4); scl = 1'b1; cw(6); sda_m = 1'b0; cw(6); scl = 1'b0;
    m_state = M_ADDR;
  endtask

  task automatic bus_stop();
    cw(2); sda_m = 1'b0; cw(4); scl = 1'b1; cw(6); sda_m = 1'b1; cw(6);
    m_state = M_IDLE;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic seen;
    for (int i = 7; i >= 0; i--) drive_bit(v[i], seen);
    model_byte(v);
    drive_bit(1'b1, seen);
    acked = !seen;
    if (m_ack) push(3, K_CLR, 0);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    logic seen;
    for (int i = 7; i > 7 - n; i--) drive_bit(v[i], seen);
  endtask

  task automatic frame(input logic [7:0] ab, input logic [7:0] cmd, input logic [7:0] d,
                       output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte(ab, a0);
    send_byte(cmd, a1);
    send_byte(d, a2);
    bus_stop();
    cw(8);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] wr_ok;
    wr_ok = {DEV, 1'b0};
    cw(5); rst_n = 1'b1; cw(5);
    // R1 reset state
    check("R1 pos_a", int'(wa), 'h80);
    check("R1 pos_b", int'(wb), 'h80);
    check("R1 tap_a bit128", int'(ta[128]), 1);
    check("R1 tap_a count", $countones(ta), 1);
    check("R1 pull", int'(pull), 0);
    run_cmp = 1;

    // R2 + R4: channel A only
    frame(wr_ok, 8'h01, 8'h3C, a0, a1, a2);
    check("R2 addr ack", int'(a0), 1);
    check("R2 cmd ack", int'(a1), 1);
    check("R2 data ack", int'(a2), 1);
    check("R4 a written", int'(wa), 'h3C);
    check("R4 b kept", int'(wb), 'h80);

    // R5: channel B only
    frame(wr_ok, 8'h02, 8'hC5, a0, a1, a2);
    check("R5 b written", int'(wb), 'hC5);
    check("R5 a kept", int'(wa), 'h3C);

    // R6: both, at both ends of the range
    frame(wr_ok, 8'h03, 8'h00, a0, a1, a2);
    check("R6 a zero", int'(wa), 0);
    check("R6 b zero", int'(wb), 0);
    check("R8 tap_a bit0", int'(ta[0]), 1);
    frame(wr_ok, 8'hF3, 8'hFF, a0, a1, a2);
    check("R6 a full", int'(wa), 'hFF);
    check("R6 b full", int'(wb), 'hFF);
    check("R8 tap_b bit255", int'(tb[255]), 1);

    // R7: no channel selected
    frame(wr_ok, 8'hFC, 8'h11, a0, a1, a2);
    check("R7 data ack", int'(a2), 1);
    check("R7 a kept", int'(wa), 'hFF);
    check("R7 b kept", int'(wb), 'hFF);

    // R3: wrong address, then read bit set
    frame({7'h2D, 1'b0}, 8'h03, 8'h12, a0, a1, a2);
    check("R3 addr nack", int'(a0), 0);
    check("R3 cmd nack", int'(a1), 0);
    check("R3 data nack", int'(a2), 0);
    check("R3 a kept", int'(wa), 'hFF);
    frame({DEV, 1'b1}, 8'h03, 8'h12, a0, a1, a2);
    check("R3 read nack", int'(a0), 0);
    check("R3 b kept", int'(wb), 'hFF);

    // R9: STOP after five data bits
    bus_start();
    send_byte(wr_ok, a0);
    send_byte(8'h01, a1);
    send_bits(8'h55, 5);
    bus_stop(); cw(8);
    check("R9 a kept", int'(wa), 'hFF);
    check("R9 b kept", int'(wb), 'hFF);

    // R10: repeated START inside the command byte, then a full frame
    bus_start();
    send_byte(wr_ok, a0);
    send_bits(8'h02, 3);
    bus_start();
    send_byte(wr_ok, a0);
    send_byte(8'h01, a1);
    send_byte(8'h77, a2);
    bus_stop(); cw(8);
    check("R10 ack after restart", int'(a0), 1);
    check("R10 a written", int'(wa), 'h77);
    check("R10 b kept", int'(wb), 'hFF);

    // R11: extra byte after data
    bus_start();
    send_byte(wr_ok, a0);
    send_byte(8'h03, a1);
    send_byte(8'h40, a2);
    send_byte(8'h99, a3);
    bus_stop(); cw(8);
    check("R11 extra nack", int'(a3), 0);
    check("R11 a", int'(wa), 'h40);
    check("R11 b", int'(wb), 'h40);
    check("R11 pull idle", int'(pull), 0);

    cw(10);
    finish_run();
  end
endmodule